// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block produces the program counter for a small processor core. Besides stepping the PC by one per advanced cycle, it runs hardware loops so that the loop body contains no branch instruction. A loop-setup instruction arms a loop. The first body address is the one following the setup instruction, and the setup supplies the final body address. Loop exit is decided by one of two rules: an iteration count, or an external termination condition sampled when the PC reaches the final body address. From then on, every cycle in which the PC sits at the final address steers the next PC back to the first body address. No extra cycle is spent, so even a one-instruction body executes once per cycle.

A separate repeat strobe is a shorthand for a one-instruction loop. It repeats the instruction that follows the strobe a counted number of times, up to 256 with the default 8-bit count. A count field of zero stands for the largest count the field can express. Only one loop is held at a time, and a setup request arriving while a loop runs has no effect. The sequential-advance enable freezes the PC and all loop state when it is low, so the core's stall logic can hold the sequencer.

Top module: `zol_sequencer`

## Requirements
- R1: After reset `pc` is 0 and `loop_active` is 0.
- R2: In a cycle with `adv_en` low, `pc`, `loop_active` and all loop state keep their values.
- R3: With no loop active, each cycle with `adv_en` high gives next `pc` = `pc` + 1, modulo 2^PC_W. This includes the cycle that issues a setup strobe.
- R4: `do_strobe` high with `adv_en` high and no loop active arms a loop. The first body address is the strobe cycle's `pc` + 1, the final body address is `loop_end`, and `loop_active` is 1 from the following cycle.
- R5: In counted mode (`do_until` = 0) with a count N from 1 to 255, the body runs exactly N times back to back. At the final address the next `pc` is the first body address on passes 1..N-1 and final + 1 on pass N. `term_cond` has no effect in this mode.
- R6: A `loop_count` of 0 runs 2^CNT_W iterations (256 by default).
- R7: A body of one instruction (final address equal to first address) runs on consecutive cycles with no gap.
- R8: In condition mode (`do_until` = 1), `term_cond` is sampled only when `pc` equals the final address. If it is 1 the loop ends and the next `pc` is final + 1; if it is 0 the next `pc` is the first body address. `loop_count` has no effect in this mode.
- R9: `loop_active` goes to 0 in the cycle after the last pass through the final address, and `pc` is then final + 1.
- R10: `do_strobe` or `rpt_strobe` while `loop_active` is 1 has no effect on `pc`, the loop bounds, the count or `loop_active`.
- R11: `rpt_strobe` with no loop active arms a counted loop whose first and final address are both `pc` + 1. It uses `loop_count` under the R5/R6 rules. When `do_strobe` and `rpt_strobe` are both high, `do_strobe` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_en | input | 1 | Sequential-advance enable; low holds all state |
| do_strobe | input | 1 | Loop setup with explicit final address |
| rpt_strobe | input | 1 | Single-instruction repeat setup |
| do_until | input | 1 | Exit rule for `do_strobe`: 0 counted, 1 condition |
| loop_end | input | PC_W | Final body address for `do_strobe` |
| loop_count | input | CNT_W | Iteration count; 0 means 2^CNT_W |
| term_cond | input | 1 | Termination condition for condition mode |
| pc | output | PC_W | Current program counter |
| loop_active | output | 1 | High while a loop is armed |

## Verification
The embedded properties check on every cycle that a stall freezes the PC, that the PC steps by one outside the final address, that a setup raises the active flag, and that the flag only drops after a visit to the final address. They also check that a condition-mode exit happens when the condition is seen there and that the counter never decrements past its last pass. Exact iteration totals cannot be seen cycle by cycle and are shown only by the bench scenarios. These include a count of zero giving 256 passes, a one-instruction body looping without gaps, the repeat shorthand, and setups ignored during a running loop.

// File: rtl/zol_pkg.sv
package zol_pkg;

   // exit rule of the armed loop
   typedef enum logic {
      ZOL_COUNTED = 1'b0,
      ZOL_UNTIL   = 1'b1
   } zol_mode_e;

endpackage

// File: rtl/zol_end_cmp.sv
module zol_end_cmp #(
   parameter int unsigned PC_W = 16
) (
   input  logic [PC_W-1:0] pc_cur,
   input  logic [PC_W-1:0] end_addr,
   input  logic            armed,
   output logic            hit
);

   generate
      if (PC_W < 2) begin : g_bad_width
         $error("zol_end_cmp: PC_W must be at least 2");
      end
   endgenerate

   // bitwise match folded into one reduction
   logic [PC_W-1:0] bit_eq;

   genvar gi;
   generate
      for (gi = 0; gi < PC_W; gi++) begin : g_eq
         assign bit_eq[gi] = ~(pc_cur[gi] ^ end_addr[gi]);
      end
   endgenerate

   assign hit = armed & (&bit_eq);

endmodule

// File: rtl/zol_iter_ctr.sv
module zol_iter_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("zol_iter_ctr: CNT_W must be at least 1");
      end
   endgenerate

   // holds passes remaining minus one; a load of 0 wraps to all ones
   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (load) begin
         rem_q <= load_val - CNT_W'(1);
      end else if (dec) begin
         rem_q <= rem_q - CNT_W'(1);
      end
   end

   assign last = (rem_q == '0);

   // R5
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> !last)
      else $error("counter decremented on its final pass");

   // R6
   zero_load_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val == '0) |=> (rem_q == {CNT_W{1'b1}}))
      else $error("zero count did not load the maximum");

endmodule

// File: rtl/zol_pc_gen.sv
module zol_pc_gen #(
   parameter int unsigned PC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic            go_back,
   input  logic [PC_W-1:0] start_addr,
   output logic [PC_W-1:0] pc_q,
   output logic [PC_W-1:0] pc_inc
);

   assign pc_inc = pc_q + PC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (adv) begin
         pc_q <= go_back ? start_addr : pc_inc;
      end
   end

   // R2
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(pc_q))
      else $error("pc moved during a stall");

   // R7
   back_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && go_back) |=> (pc_q == $past(start_addr)))
      else $error("loop-back did not land on the start address");

endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer
   import zol_pkg::*;
#(
   parameter int unsigned PC_W     = 16,
   parameter int unsigned CNT_W    = 8,
   parameter bit          UNTIL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_en,
   input  logic             do_strobe,
   input  logic             rpt_strobe,
   input  logic             do_until,
   input  logic [PC_W-1:0]  loop_end,
   input  logic [CNT_W-1:0] loop_count,
   input  logic             term_cond,
   output logic [PC_W-1:0]  pc,
   output logic             loop_active
);

   generate
      if (PC_W < 2 || PC_W > 32) begin : g_bad_pc
         $error("zol_sequencer: PC_W must be within 2..32");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("zol_sequencer: CNT_W must be within 1..16");
      end
   endgenerate

   // loop state
   logic [PC_W-1:0] start_q;
   logic [PC_W-1:0] end_q;
   zol_mode_e       mode_q;
   logic            active_q;

   // control
   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_inc;
   logic            at_end;
   logic            last_pass;
   logic            arm;
   logic            until_sel;
   zol_mode_e       arm_mode;
   logic [PC_W-1:0] arm_end;
   logic            exit_now;
   logic            take_back;
   logic            ctr_dec;

   // condition mode may be compiled out
   generate
      if (UNTIL_EN) begin : g_until
         assign until_sel = do_until;
      end else begin : g_count_only
         assign until_sel = 1'b0;
      end
   endgenerate

   assign arm      = adv_en & ~active_q & (do_strobe | rpt_strobe);
   assign arm_end  = do_strobe ? loop_end : pc_inc;
   assign arm_mode = (do_strobe && until_sel) ? ZOL_UNTIL : ZOL_COUNTED;

   assign exit_now  = adv_en & at_end &
                      ((mode_q == ZOL_UNTIL) ? term_cond : last_pass);
   assign take_back = adv_en & at_end & ~exit_now;
   assign ctr_dec   = take_back & (mode_q == ZOL_COUNTED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q  <= '0;
         end_q    <= '0;
         mode_q   <= ZOL_COUNTED;
         active_q <= 1'b0;
      end else if (arm) begin
         start_q  <= pc_inc;
         end_q    <= arm_end;
         mode_q   <= arm_mode;
         active_q <= 1'b1;
      end else if (exit_now) begin
         active_q <= 1'b0;
      end
   end

   zol_end_cmp #(.PC_W(PC_W)) u_cmp (
      .pc_cur   (pc_q),
      .end_addr (end_q),
      .armed    (active_q),
      .hit      (at_end)
   );

   zol_iter_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (arm),
      .load_val (loop_count),
      .dec      (ctr_dec),
      .last     (last_pass)
   );

   zol_pc_gen #(.PC_W(PC_W)) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (adv_en),
      .go_back    (take_back),
      .start_addr (start_q),
      .pc_q       (pc_q),
      .pc_inc     (pc_inc)
   );

   assign pc          = pc_q;
   assign loop_active = active_q;

   // R3
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !loop_active) |=> (pc == $past(pc) + PC_W'(1)))
      else $error("pc did not step by one outside a loop");

   // R5
   body_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && loop_active && !at_end) |=> (pc == $past(pc) + PC_W'(1)))
      else $error("pc did not step by one inside the body");

   // R4
   arm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !loop_active && (do_strobe || rpt_strobe)) |=> loop_active)
      else $error("setup strobe did not arm a loop");

   // R9
   exit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(loop_active) |-> ($past(at_end) && pc == $past(pc) + PC_W'(1)))
      else $error("loop ended away from the final address");

   // R8
   until_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && at_end && mode_q == ZOL_UNTIL && term_cond) |=> !loop_active)
      else $error("condition seen at the final address did not end the loop");

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_active && !at_end) |=> ($stable(start_q) && $stable(end_q) && loop_active))
      else $error("loop state changed while a loop was running");

endmodule

// File: tb/tb_zol_sequencer.sv
`timescale 1ns/1ps
module tb_zol_sequencer;

   localparam int PC_W  = 16;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             adv_en = 1'b0;
   logic             do_strobe = 1'b0;
   logic             rpt_strobe = 1'b0;
   logic             do_until = 1'b0;
   logic [PC_W-1:0]  loop_end = '0;
   logic [CNT_W-1:0] loop_count = '0;
   logic             term_cond = 1'b0;
   logic [PC_W-1:0]  pc;
   logic             loop_active;

   always #10 clk = ~clk;

   zol_sequencer #(.PC_W(PC_W), .CNT_W(CNT_W), .UNTIL_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .do_strobe(do_strobe),
      .rpt_strobe(rpt_strobe), .do_until(do_until), .loop_end(loop_end),
      .loop_count(loop_count), .term_cond(term_cond), .pc(pc),
      .loop_active(loop_active)
   );

   typedef struct {
      logic [PC_W-1:0] pc;
      bit              act;
      string           req;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp  = 0;
   int   n_bad  = 0;
   bit   done   = 0;
   logic [PC_W-1:0] epc;

   // monitor: one expected item per clock edge after the driver starts
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_cmp++;
         if (pc !== e.pc || loop_active !== e.act) begin
            n_bad++;
            $display("FAIL %s: pc=%0d active=%0b expected pc=%0d active=%0b",
                     e.req, pc, loop_active, e.pc, e.act);
         end
      end
   end

   // driver: set inputs for the next edge and queue the expected state
   task automatic step(input bit adv, input bit dstb, input bit rstb,
                       input bit untl, input bit cond,
                       input logic [PC_W-1:0] endv, input logic [CNT_W-1:0] cnt,
                       input logic [PC_W-1:0] xpc, input bit xact, input string req);
      exp_t e;
      @(negedge clk);
      adv_en     = adv;
      do_strobe  = dstb;
      rpt_strobe = rstb;
      do_until   = untl;
      term_cond  = cond;
      loop_end   = endv;
      loop_count = cnt;
      e.pc = xpc; e.act = xact; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic run_seq(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         step(1, 0, 0, 0, 1, '0, '0, epc + 1'b1, 0, req);
         epc = epc + 1'b1;
      end
   endtask

   // arm a loop then walk it; inject a busy setup at body step inj,
   // stall at body step stl (negative disables)
   task automatic run_loop(input bit rpt, input bit untl,
                           input logic [PC_W-1:0] endv, input logic [CNT_W-1:0] cnt,
                           input int n_iter, input int inj, input int stl,
                           input string req);
      logic [PC_W-1:0] s, e, nxt;
      int k;
      s = epc + 1'b1;
      e = rpt ? s : endv;
      step(1, !rpt, rpt, untl, 0, endv, cnt, s, 1, req);
      epc = s;
      k = 0;
      for (int it = 1; it <= n_iter; it++) begin
         for (int a = int'(s); a <= int'(e); a++) begin
            bit fin;
            bit cond;
            fin = (a == int'(e)) && (it == n_iter);
            if (k == stl) begin
               step(0, 0, 0, 0, 1, '0, '0, epc, 1, "R2");
            end
            nxt = (a == int'(e)) ? (fin ? e + 1'b1 : s) : PC_W'(a + 1);
            // counted: condition high everywhere (ignored); until: high only off-end or on last pass
            cond = untl ? ((a == int'(e)) ? fin : 1'b1) : 1'b1;
            if (k == inj) begin
               step(1, 1, 1, 0, cond, e + 16'd5, 8'd1, nxt, !fin, "R10");
            end else begin
               step(1, 0, 0, 0, cond, '0, '0, nxt, !fin, req);
            end
            epc = nxt;
            k++;
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      n_cmp++;
      if (pc !== '0 || loop_active !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: pc=%0d active=%0b expected pc=0 active=0", pc, loop_active);
      end
      epc = '0;
      run_seq(3, "R3");
      // R2 stall holds
      step(0, 0, 0, 0, 0, '0, '0, epc, 0, "R2");
      step(0, 1, 0, 0, 0, 16'd9, 8'd2, epc, 0, "R2");
      // R5 counted loop, 3 passes over 4..6
      run_loop(0, 0, 16'd6, 8'd3, 3, -1, -1, "R5");
      // R6/R7 count zero, one-instruction body
      run_loop(0, 0, epc + 1'b1, 8'd0, 256, -1, -1, "R6");
      // R11 repeat shorthand, 4 times
      run_loop(1, 0, 16'd0, 8'd4, 4, -1, -1, "R11");
      // R8 condition mode, exit on pass 3, count field ignored
      run_loop(0, 1, epc + 16'd2, 8'd1, 3, -1, -1, "R8");
      // R10 busy setup ignored, R2 stall inside loop
      run_loop(0, 0, epc + 16'd3, 8'd2, 2, 1, 4, "R9");
      // R7 single-instruction counted body of 2, R4 start after setup
      run_loop(0, 0, epc + 1'b1, 8'd2, 2, -1, -1, "R7");
      // R11 priority: both strobes, do wins with loop_end
      begin
         logic [PC_W-1:0] s;
         s = epc + 1'b1;
         step(1, 1, 1, 0, 0, s + 1'b1, 8'd1, s, 1, "R11");
         step(1, 0, 0, 0, 0, '0, '0, s + 1'b1, 1, "R11");
         step(1, 0, 0, 0, 0, '0, '0, s + 16'd2, 0, "R11");
         epc = s + 16'd2;
      end
      run_seq(2, "R4");
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule